// File: doc/BRIEF.md
# Byte-Packing Receive Queue

This block sits between a 24-bit serial receive shift register and a local processor. Each time the serial side finishes a transfer it pulses a load strobe together with the current shift-register contents. The block keeps the one, two or three most significant bytes of that value, as chosen by a byte-mode input. It places them at the top of a 24-bit word, fills the unused low bits with zeros, and appends the word to a ten-entry first-in-first-out queue.

The processor sees the oldest entry on the read-data output at all times, with no read latency. A read strobe retires that entry. Loading and reading may happen in the same cycle, and both take effect. Registered not-empty and full flags follow the occupancy. A sticky overrun flag records any load that was lost because the queue was full. Four conditions flush the queue to empty and clear its storage and the overrun flag: hardware reset, a software reset pulse, the interface enable held low, and a stop-mode request.

The control path is a four-state machine. EMPTY holds no entries. PARTIAL holds between one and nine. FULL holds ten. FLUSH is held while any synchronous clear source is active. The transitions are:
- flush_any: from any state to FLUSH.
- release: from FLUSH to EMPTY, or to PARTIAL if a load arrives in the release cycle.
- first_load: from EMPTY to PARTIAL.
- fill: from PARTIAL to FULL.
- drain: from PARTIAL to EMPTY.
- unfill: from FULL to PARTIAL, on a read without a load.
- hold: stay in the same state.

Top module: `byte_rx_fifo`

## Requirements
- R1: After hardware reset (`rst_n` low, asynchronous), `not_empty`, `full` and `overrun` are 0 and `rd_data` is 0.
- R2: With `byte_mode` = 2'b00, a load stores `{shift_word[23:16], 16'h0000}`.
- R3: With `byte_mode` = 2'b01, a load stores `{shift_word[23:8], 8'h00}`.
- R4: With `byte_mode` = 2'b10 or 2'b11, a load stores `shift_word` unchanged.
- R5: `rd_data` always shows the oldest stored entry. A `rd` pulse while not empty retires it, and entries leave in load order. The queue holds 10 entries.
- R6: `not_empty` and `full` are registered. Each is valid from the clock edge that performs a load or read. `full` is 1 exactly when 10 entries are held.
- R7: A load while full and without a read in the same cycle is discarded and sets `overrun`. `overrun` stays at 1 until a flush or reset.
- R8: A read while empty leaves the queue unchanged, and `rd_data` reads 0 while empty.
- R9: A load and a read in the same cycle both take effect, including when the queue is full. In that case it stays full and no overrun is raised.
- R10: While `sw_rst` is 1, `if_en` is 0 or `stop_req` is 1, the queue is emptied on the next edge, `overrun` is cleared, and loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| if_en | input | 1 | Interface enable; 0 holds the queue flushed |
| stop_req | input | 1 | Stop-mode request; 1 holds the queue flushed |
| byte_mode | input | 2 | 00 one byte, 01 two bytes, 10/11 three bytes |
| load | input | 1 | Shift-register word complete strobe |
| shift_word | input | 24 | Shift-register contents at the load |
| rd | input | 1 | Processor read strobe (retires oldest entry) |
| rd_data | output | 24 | Oldest entry, 0 when empty |
| not_empty | output | 1 | Registered: at least one entry held |
| full | output | 1 | Registered: 10 entries held |
| overrun | output | 1 | Sticky: a load was lost while full |

## Verification
The assertions assume that the clear sources are synchronous to `clk`. They also assume that `rd` and `load` are single-cycle levels sampled at the rising edge, with no relation required between them. The bench changes every input only on the falling edge. It holds each clear source for whole cycles and drives loads and reads in any combination, including both in one cycle at the empty and full boundaries. It therefore stays inside those assumptions while still reaching every transition.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned WORD_W  = 24;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned Q_DEPTH = 10;

    typedef enum logic [1:0] {
        BM_ONE   = 2'b00,
        BM_TWO   = 2'b01,
        BM_THREE = 2'b10,
        BM_ALL   = 2'b11
    } bytemode_e;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL,
        Q_FLUSH
    } qstate_e;

endpackage

// File: rtl/rxq_align.sv
module rxq_align #(
    parameter int unsigned WORD_W = rxq_pkg::WORD_W,
    parameter int unsigned BYTE_W = rxq_pkg::BYTE_W
) (
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] packed_word
);
    import rxq_pkg::*;

    localparam int unsigned NBYTES = WORD_W / BYTE_W;
    localparam int unsigned KEEP_W = $clog2(NBYTES + 1);

    logic [KEEP_W-1:0] keep;

    always_comb begin
        unique case (bytemode_e'(mode))
            BM_ONE:   keep = KEEP_W'(1);
            BM_TWO:   keep = KEEP_W'(2);
            BM_THREE: keep = KEEP_W'(NBYTES);
            BM_ALL:   keep = KEEP_W'(NBYTES);
            default:  keep = KEEP_W'(NBYTES);
        endcase
    end

    // byte k counts down from the most significant lane
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam int unsigned HI = WORD_W - 1 - k * BYTE_W;
        assign packed_word[HI -: BYTE_W] =
            (KEEP_W'(k) < keep) ? raw[HI -: BYTE_W] : '0;
    end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int unsigned DEPTH = rxq_pkg::Q_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             not_empty,
    output logic             full,
    output logic             overrun
);
    import rxq_pkg::*;

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    qstate_e          state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic             pop_ok, push_ok, drop;

    always_comb begin
        pop_ok  = pop && (count_q != '0) && !flush;
        push_ok = push && !flush && ((count_q != CNT_TOP) || pop_ok);
        drop    = push && !flush && (count_q == CNT_TOP) && !pop_ok;
        count_n = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    assign wr_en = push_ok;

    // next state
    always_comb begin
        state_n = state_q;
        if (flush) begin
            state_n = Q_FLUSH;                                   // flush_any
        end else begin
            unique case (state_q)
                Q_FLUSH:   state_n = push_ok ? Q_PARTIAL : Q_EMPTY; // release
                Q_EMPTY:   state_n = push_ok ? Q_PARTIAL : Q_EMPTY; // first_load
                Q_PARTIAL: begin
                    if (count_n == CNT_TOP)  state_n = Q_FULL;      // fill
                    else if (count_n == '0)  state_n = Q_EMPTY;     // drain
                    else                     state_n = Q_PARTIAL;
                end
                Q_FULL:    state_n = (pop_ok && !push_ok) ? Q_PARTIAL : Q_FULL; // unfill
                default:   state_n = Q_EMPTY;
            endcase
        end
    end

    // state register with occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else if (flush) begin
            state_q <= Q_FLUSH;
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            not_empty <= 1'b0;
            full      <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            not_empty <= (state_n == Q_PARTIAL) || (state_n == Q_FULL);
            full      <= (state_n == Q_FULL);
            if (flush)     overrun <= 1'b0;
            else if (drop) overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH  = rxq_pkg::Q_DEPTH,
    parameter int unsigned WORD_W = rxq_pkg::WORD_W,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_ptr == PTR_W'(i)) slot_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_valid)
            for (int i = 0; i < DEPTH; i++)
                if (rd_ptr == PTR_W'(i)) rd_data = slot_q[i];
    end

endmodule

// File: rtl/byte_rx_fifo.sv
module byte_rx_fifo #(
    parameter int unsigned DEPTH  = rxq_pkg::Q_DEPTH,
    parameter int unsigned WORD_W = rxq_pkg::WORD_W,
    parameter int unsigned BYTE_W = rxq_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              if_en,
    input  logic              stop_req,
    input  logic [1:0]        byte_mode,
    input  logic              load,
    input  logic [WORD_W-1:0] shift_word,
    input  logic              rd,
    output logic [WORD_W-1:0] rd_data,
    output logic              not_empty,
    output logic              full,
    output logic              overrun
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic              flush;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [WORD_W-1:0] packed_word;

    assign flush = sw_rst || !if_en || stop_req;

    rxq_align #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_align (
        .mode        (byte_mode),
        .raw         (shift_word),
        .packed_word (packed_word)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (load),
        .pop       (rd),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .not_empty (not_empty),
        .full      (full),
        .overrun   (overrun)
    );

    rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_data  (packed_word),
        .rd_ptr   (rd_ptr),
        .rd_valid (not_empty),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned WORD_W = rxq_pkg::WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              if_en,
    input logic              stop_req,
    input logic              load,
    input logic              rd,
    input logic [WORD_W-1:0] rd_data,
    input logic              not_empty,
    input logic              full,
    input logic              overrun
);

    logic clr_any;
    assign clr_any = sw_rst || !if_en || stop_req;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (!not_empty && !full && !overrun)); // R10

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> (rd_data == '0)); // R8

    AST_EMPTY_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && rd && !load && !clr_any) |=> !not_empty); // R8

    AST_FULL_IMPLIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> not_empty); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && !rd && !clr_any) |=> (full && overrun)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_any) |=> overrun); // R7

    AST_FULL_SWAP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && rd && !clr_any && !overrun) |=> (full && !overrun)); // R9

endmodule

bind byte_rx_fifo rxq_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .if_en     (if_en),
    .stop_req  (stop_req),
    .load      (load),
    .rd        (rd),
    .rd_data   (rd_data),
    .not_empty (not_empty),
    .full      (full),
    .overrun   (overrun)
);

// File: tb/sim_byte_rx_fifo.sv
`timescale 1ns/1ps
module sim_byte_rx_fifo;

    localparam int DEPTH = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        if_en = 1'b1;
    logic        stop_req = 1'b0;
    logic [1:0]  byte_mode = 2'b10;
    logic        load = 1'b0;
    logic [23:0] shift_word = '0;
    logic        rd = 1'b0;
    logic [23:0] rd_data;
    logic        not_empty, full, overrun;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    byte_rx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .if_en(if_en),
        .stop_req(stop_req), .byte_mode(byte_mode), .load(load),
        .shift_word(shift_word), .rd(rd), .rd_data(rd_data),
        .not_empty(not_empty), .full(full), .overrun(overrun)
    );

    function automatic logic [23:0] pack(input logic [1:0] m, input logic [23:0] w);
        case (m)
            2'b00:   return {w[23:16], 16'h0000};
            2'b01:   return {w[23:8], 8'h00};
            default: return w;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(not_empty == (exp_q.size() != 0), {req, " not_empty"}, 24'(not_empty), 24'(exp_q.size() != 0));
        check(full == (exp_q.size() == DEPTH), {req, " full"}, 24'(full), 24'(exp_q.size() == DEPTH));
    endtask

    // driver: all tasks start and end at a falling edge
    task automatic drive_load(input logic [1:0] m, input logic [23:0] w, input string req);
        byte_mode = m; shift_word = w; load = 1'b1;
        if (exp_q.size() < DEPTH) begin
            exp_q.push_back(pack(m, w));
            tag_q.push_back(req);
        end
        @(negedge clk);
        load = 1'b0;
    endtask

    // monitor side: compare head against scoreboard, then retire it
    task automatic take_head();
        string req;
        req = tag_q[0];
        check(not_empty && rd_data == exp_q[0], req, rd_data, exp_q[0]);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
    endtask

    task automatic swap(input logic [1:0] m, input logic [23:0] w, input string req);
        check(rd_data == exp_q[0], {req, " head"}, rd_data, exp_q[0]);
        byte_mode = m; shift_word = w; load = 1'b1; rd = 1'b1;
        @(negedge clk);
        load = 1'b0; rd = 1'b0;
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        exp_q.push_back(pack(m, w));
        tag_q.push_back(req);
    endtask

    task automatic drain(input string req);
        while (exp_q.size() != 0) take_head();
        check_flags(req);
    endtask

    task automatic expect_flushed(input string req);
        exp_q.delete();
        tag_q.delete();
        check(!not_empty && !full, {req, " flags"}, {22'h0, not_empty, full}, 24'h0);
        check(!overrun, {req, " overrun"}, 24'(overrun), 24'h0);
        check(rd_data == 24'h0, {req, " data"}, rd_data, 24'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_flushed("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_flushed("R1 after reset");

        // packing modes
        drive_load(2'b00, 24'hABCDEF, "R2 single byte");
        check_flags("R6 after first load");
        drive_load(2'b01, 24'hABCDEF, "R3 double byte");
        drive_load(2'b10, 24'h123456, "R4 triple byte");
        drive_load(2'b11, 24'hFEDCBA, "R4 mode 11 as triple");
        drive_load(2'b00, 24'h00FFFF, "R2 low bits discarded");
        check_flags("R6 partial");
        drain("R5 drain in order");

        // empty read leaves pointers alone
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(rd_data == 24'h0 && !not_empty, "R8 empty read", rd_data, 24'h0);
        drive_load(2'b10, 24'h5A5A5A, "R8 load after empty read");
        take_head();

        // fill, overflow, sticky overrun
        for (int i = 0; i < DEPTH; i++)
            drive_load(2'b10, 24'(i * 24'h010203 + 24'h100000), "R5 fill");
        check_flags("R6 full at ten");
        drive_load(2'b10, 24'hDEAD00, "R7 dropped load");
        check(overrun == 1'b1, "R7 overrun set", 24'(overrun), 24'h1);
        check_flags("R7 still full");
        take_head();
        check(overrun == 1'b1, "R7 overrun sticky", 24'(overrun), 24'h1);

        // sw reset clears overrun and contents
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        expect_flushed("R10 software reset");

        // simultaneous load and read at full
        for (int i = 0; i < DEPTH; i++)
            drive_load(2'b01, 24'(24'h0A0B0C + i * 24'h001100), "R9 refill");
        swap(2'b10, 24'h777777, "R9 swap at full");
        check_flags("R9 full kept");
        check(overrun == 1'b0, "R9 no overrun on swap", 24'(overrun), 24'h0);
        drain("R9 drain after full swap");

        // simultaneous load and read with one entry
        drive_load(2'b10, 24'h111111, "R9 single");
        swap(2'b00, 24'h222222, "R9 swap at one");
        check_flags("R9 one entry kept");
        drain("R9 drain after swap");

        // interface enable low, with overrun raised first
        for (int i = 0; i <= DEPTH; i++)
            drive_load(2'b10, 24'(24'h300000 + i), "R10 preload");
        if_en = 1'b0;
        @(negedge clk);
        expect_flushed("R10 enable low");
        if_en = 1'b1;

        // stop mode: loads ignored while held
        drive_load(2'b10, 24'h444444, "R10 pre-stop");
        stop_req = 1'b1;
        @(negedge clk);
        byte_mode = 2'b10; shift_word = 24'h999999; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        stop_req = 1'b0;
        @(negedge clk);
        expect_flushed("R10 stop mode load ignored");

        // hardware reset mid-stream
        drive_load(2'b01, 24'h556677, "R1 pre-reset");
        drive_load(2'b01, 24'h889900, "R1 pre-reset");
        rst_n = 1'b0;
        #1;
        expect_flushed("R1 asynchronous reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive_load(2'b00, 24'hC3C3C3, "R2 after reset");
        drain("R5 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule